// File: doc/BRIEF.md
# Slave Demand Power Controller

This block decides, at the slave end of a burst-mode loop link, whether the slave may transmit and when. It watches a one-cycle strobe from the demodulator that marks the end of each received master burst, and the resolved level of a shared power-down pin. The pin is driven weakly by this block and may be overridden by external logic. Each demodulated master burst pulls the pin high. A silence of 250 µs pulls it low. That lets the slave power itself up and down on demand.

When the pin is high and master bursts arrive, every burst gets one response: a burst request to the modulator and a strobe that samples the signaling inputs. When the pin is held high but no master burst has come within the timeout, the block runs a free-running frame of 125 µs. It samples signaling on every frame edge and requests a burst on every other frame edge. A master burst that arrives during the free-running mode brings the block back to demodulation-synchronised operation. While the pin is low, the block issues no burst request and no signaling sample. The weak driver and the silence timer keep running.

All timing is counted in cycles of the 4.096 MHz clock. The timeout is 1024 cycles and the frame is 512 cycles, and both are parameters.

Top module: `slave_demand_power_ctl`

## Requirements
- R1: After reset, `pd_drive_en`, `pd_drive_val`, `frame_tick`, `burst_req` and `sig_sample` are 0. `pd_drive_en` stays 0 until the first demodulation strobe or the first timeout expiry.
- R2: With `pd_pin` high, a `demod_done` sampled at a clock edge makes `burst_req` and `sig_sample` 1 for exactly the following cycle.
- R3: While `pd_pin` is low at the sampling edge, `burst_req` and `sig_sample` stay 0, whether or not `demod_done` is present.
- R4: A `demod_done` sampled at an edge makes `pd_drive_en` and `pd_drive_val` both 1 from that edge on, whatever the pin level.
- R5: The silence timer restarts on each `demod_done`. When TIMEOUT_CYC edges pass with no restart, `pd_drive_val` becomes 0 at the last of those edges and `pd_drive_en` is 1. `pd_drive_val` does not fall earlier.
- R6: While `pd_pin` is high and the timeout has expired, `frame_tick` pulses for one cycle every FRAME_CYC cycles. The first pulse comes FRAME_CYC edges after the expiry edge.
- R7: In the free-running mode, `sig_sample` pulses together with every `frame_tick`. `burst_req` pulses together with the 1st, 3rd, 5th and later odd-numbered `frame_tick` of that run when FREE_BURST_FIRST=1 (the default), and with the even-numbered ones otherwise.
- R8: A `demod_done` during the free-running mode ends it. That demodulation gets a normal R2 response, and no `frame_tick` follows until a new full timeout has expired.
- R9: A rising edge of `pd_pin` restarts the silence timer. After the rise, the free-running mode starts only after TIMEOUT_CYC further edges without a restart, and its burst alternation begins afresh.
- R10: While `pd_pin` is low, `frame_tick` stays 0 even after the timeout has expired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.096 MHz oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| demod_done | input | 1 | One-cycle strobe marking the end of a demodulated master burst |
| pd_pin | input | 1 | Resolved level of the shared power-down pin (1 = powered up) |
| pd_drive_en | output | 1 | Enable of the weak driver on the power-down pin |
| pd_drive_val | output | 1 | Value the weak driver tries to put on the power-down pin |
| frame_tick | output | 1 | One-cycle pulse on each edge of the free-running frame clock |
| burst_req | output | 1 | One-cycle request to the modulator to send a burst to the master |
| sig_sample | output | 1 | One-cycle strobe to latch the signaling inputs |

## Verification
The bench uses a small configuration: a timeout of 16 cycles and a frame of 4 cycles. It sweeps every cycle of the silence window, so a timer that is off by one is seen as a weak-drive value that falls one cycle early or late. It follows several free-running frames in a row, so a framer that bursts on every tick, or starts the alternation on the wrong tick, shows up as a misplaced `burst_req`. It also covers three cases where a design could fail to stop or restart correctly:
- A demodulation arriving mid-fallback, where a block that did not leave the free-running mode would keep producing ticks.
- A long low-pin interval, where transmit requests or ticks must stay silent.
- A pin rising after expiry, where a design that ignored the rise would start ticking at once instead of after a fresh timeout.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   // Operating mode of the slave power controller
   typedef enum logic [1:0] {
      DPC_DOWN = 2'd0,   // pin low: receive side only
      DPC_SYNC = 2'd1,   // pin high, paced by master bursts
      DPC_FREE = 2'd2    // pin high, master silent: own frame clock
   } dpc_mode_e;
endpackage

// File: rtl/dpc_silence_timer.sv
module dpc_silence_timer #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired,
   output logic hit_now
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("dpc_silence_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q, cnt_d;

   always_comb begin
      if (restart)          cnt_d = '0;
      else if (cnt_q == LIM) cnt_d = cnt_q;
      else                  cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign expired = (cnt_q == LIM);
   // true only on the edge that completes the silent window
   assign hit_now = (cnt_d == LIM) && (cnt_q != LIM);

   p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);
   p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expired);
   p_hit_then_expired_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_now |=> expired);
endmodule

// File: rtl/dpc_free_framer.sv
module dpc_free_framer #(
   parameter int FRAME       = 512,
   parameter bit BURST_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick,
   output logic burst_slot
);
   localparam int W = (FRAME > 1) ? $clog2(FRAME) : 1;
   localparam logic [W-1:0] LAST = W'(FRAME - 1);

   generate
      if (FRAME < 2) begin : g_bad_frame
         $error("dpc_free_framer: FRAME must be at least 2");
      end
   endgenerate

   logic [W-1:0] pos_q;
   logic         odd_q;   // 0 before 1st tick of a run, toggles per tick

   assign tick = run && (pos_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pos_q <= '0;
         odd_q <= 1'b0;
      end else begin
         pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
         if (tick) odd_q <= ~odd_q;
      end
   end

   generate
      if (BURST_FIRST) begin : g_burst_odd
         assign burst_slot = tick && !odd_q;
      end else begin : g_burst_even
         assign burst_slot = tick && odd_q;
      end
   endgenerate

   p_idle_rewinds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pos_q == '0) && !odd_q);
   p_slot_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_slot |-> tick);
   p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick && run |=> run |-> (odd_q != $past(odd_q)));
endmodule

// File: rtl/dpc_weak_driver.sv
module dpc_weak_driver (
   input  logic clk,
   input  logic rst_n,
   input  logic pull_up,
   input  logic pull_down,
   output logic drv_en,
   output logic drv_val
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drv_en  <= 1'b0;
         drv_val <= 1'b0;
      end else begin
         drv_en <= drv_en | pull_up | pull_down;
         if (pull_up)        drv_val <= 1'b1;
         else if (pull_down) drv_val <= 1'b0;
      end
   end

   p_up_after_demod_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pull_up |=> drv_en && drv_val);
   p_down_after_silence_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pull_down && !pull_up |=> drv_en && !drv_val);
   p_en_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |=> drv_en);
endmodule

// File: rtl/slave_demand_power_ctl.sv
module slave_demand_power_ctl #(
   parameter int TIMEOUT_CYC      = 1024,
   parameter int FRAME_CYC        = 512,
   parameter bit FREE_BURST_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic demod_done,
   input  logic pd_pin,
   output logic pd_drive_en,
   output logic pd_drive_val,
   output logic frame_tick,
   output logic burst_req,
   output logic sig_sample
);
   import dpc_pkg::*;

   generate
      if (FRAME_CYC >= TIMEOUT_CYC) begin : g_bad_ratio
         $error("slave_demand_power_ctl: FRAME_CYC must be below TIMEOUT_CYC");
      end
   endgenerate

   logic      pd_q, pd_rise, restart;
   logic      expired, hit_now;
   logic      free_run, f_tick, f_slot;
   dpc_mode_e mode;

   always_ff @(posedge clk) begin
      if (!rst_n) pd_q <= 1'b0;
      else        pd_q <= pd_pin;
   end

   assign pd_rise  = pd_pin && !pd_q;
   assign restart  = demod_done || pd_rise;
   assign free_run = pd_pin && expired;

   always_comb begin
      if (!pd_pin)       mode = DPC_DOWN;
      else if (expired)  mode = DPC_FREE;
      else               mode = DPC_SYNC;
   end

   dpc_silence_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .expired (expired),
      .hit_now (hit_now)
   );

   dpc_free_framer #(.FRAME(FRAME_CYC), .BURST_FIRST(FREE_BURST_FIRST)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (free_run),
      .tick       (f_tick),
      .burst_slot (f_slot)
   );

   dpc_weak_driver u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .pull_up   (demod_done),
      .pull_down (hit_now),
      .drv_en    (pd_drive_en),
      .drv_val   (pd_drive_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_tick <= 1'b0;
         burst_req  <= 1'b0;
         sig_sample <= 1'b0;
      end else begin
         frame_tick <= f_tick;
         unique case (mode)
            DPC_DOWN: begin
               burst_req  <= 1'b0;
               sig_sample <= 1'b0;
            end
            DPC_SYNC: begin
               burst_req  <= demod_done;
               sig_sample <= demod_done;
            end
            default: begin
               burst_req  <= demod_done || f_slot;
               sig_sample <= demod_done || f_tick;
            end
         endcase
      end
   end

   p_burst_needs_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> $past(pd_pin));
   p_sample_with_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req |-> sig_sample);
   p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |=> !frame_tick);
   p_free_burst_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req && !$past(demod_done) |-> frame_tick);
   p_no_tick_when_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |-> $past(pd_pin));
endmodule

// File: tb/slave_demand_power_ctl_tb.sv
module slave_demand_power_ctl_tb;
   localparam int TMO = 16;
   localparam int FRM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic demod_done = 1'b0;
   logic pd_pin = 1'b0;
   logic pd_drive_en, pd_drive_val, frame_tick, burst_req, sig_sample;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   slave_demand_power_ctl #(.TIMEOUT_CYC(TMO), .FRAME_CYC(FRM), .FREE_BURST_FIRST(1'b1)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .demod_done   (demod_done),
      .pd_pin       (pd_pin),
      .pd_drive_en  (pd_drive_en),
      .pd_drive_val (pd_drive_val),
      .frame_tick   (frame_tick),
      .burst_req    (burst_req),
      .sig_sample   (sig_sample)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   // apply inputs at a falling edge, let one rising edge sample them,
   // return at the next falling edge with registered outputs settled
   task automatic step(input logic d, input logic p);
      demod_done = d;
      pd_pin     = p;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (3) step(1'b0, 1'b0);
      rst_n = 1'b1;
      // R1: reset state and idle with low pin, no demod yet (timer not expired)
      chk("R1", "drive_en", pd_drive_en, 1'b0);
      chk("R1", "drive_val", pd_drive_val, 1'b0);
      chk("R1", "frame_tick", frame_tick, 1'b0);
      chk("R1", "burst_req", burst_req, 1'b0);
      chk("R1", "sig_sample", sig_sample, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R1", "drive_en idle", pd_drive_en, 1'b0);

      // R2 / R4: powered, one master burst
      step(1'b1, 1'b1);
      chk("R2", "burst_req", burst_req, 1'b1);
      chk("R2", "sig_sample", sig_sample, 1'b1);
      chk("R4", "drive_en", pd_drive_en, 1'b1);
      chk("R4", "drive_val", pd_drive_val, 1'b1);

      // R5: sweep the silence window edge by edge
      for (int n = 1; n <= TMO; n++) begin
         step(1'b0, 1'b1);
         if (n == 1) begin
            chk("R2", "burst_req one-shot", burst_req, 1'b0);
            chk("R2", "sig_sample one-shot", sig_sample, 1'b0);
         end
         chk("R5", $sformatf("drive_val n=%0d", n), pd_drive_val, (n < TMO));
         chk("R6", $sformatf("no tick n=%0d", n), frame_tick, 1'b0);
      end
      chk("R5", "drive_en", pd_drive_en, 1'b1);

      // R6 / R7: free-running frames after expiry
      for (int m = 1; m <= 5 * FRM; m++) begin
         logic et, eb;
         step(1'b0, 1'b1);
         et = (m % FRM == 0);
         eb = et && (((m / FRM) % 2) == 1);
         chk("R6", $sformatf("frame_tick m=%0d", m), frame_tick, et);
         chk("R7", $sformatf("burst_req m=%0d", m), burst_req, eb);
         chk("R7", $sformatf("sig_sample m=%0d", m), sig_sample, et);
      end

      // R8: master burst during fallback returns to synchronised mode
      step(1'b1, 1'b1);
      chk("R8", "burst_req response", burst_req, 1'b1);
      chk("R8", "sig_sample response", sig_sample, 1'b1);
      chk("R8", "drive_val up", pd_drive_val, 1'b1);
      for (int n = 1; n <= TMO; n++) begin
         step(1'b0, 1'b1);
         chk("R8", $sformatf("no tick n=%0d", n), frame_tick, 1'b0);
         chk("R8", $sformatf("no burst n=%0d", n), burst_req, 1'b0);
         chk("R5", $sformatf("drive_val after exit n=%0d", n), pd_drive_val, (n < TMO));
      end

      // R3 / R10: pin low, demod still pulls up but nothing transmits
      step(1'b1, 1'b0);
      chk("R3", "burst_req low pin", burst_req, 1'b0);
      chk("R3", "sig_sample low pin", sig_sample, 1'b0);
      chk("R4", "drive_val low pin", pd_drive_val, 1'b1);
      for (int n = 1; n <= TMO + 3 * FRM; n++) begin
         step(1'b0, 1'b0);
         chk("R10", $sformatf("no tick low n=%0d", n), frame_tick, 1'b0);
         chk("R3", $sformatf("no burst low n=%0d", n), burst_req, 1'b0);
         chk("R5", $sformatf("drive_val low n=%0d", n), pd_drive_val, (n < TMO));
      end

      // R9: pin rises after expiry -> fresh timeout before free-running
      step(1'b0, 1'b1);
      chk("R9", "no tick on rise", frame_tick, 1'b0);
      for (int n = 1; n <= TMO + 3 * FRM; n++) begin
         logic et, eb;
         step(1'b0, 1'b1);
         et = (n >= TMO + FRM) && ((n - TMO) % FRM == 0);
         eb = et && ((((n - TMO) / FRM) % 2) == 1);
         chk("R9", $sformatf("frame_tick n=%0d", n), frame_tick, et);
         chk("R9", $sformatf("burst_req n=%0d", n), burst_req, eb);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule